// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog peripheral on a simple single-cycle register bus. A down-counter of `CNT_W` bits (32 by default) runs once software sets the enable bit in the control register. The first time the counter reaches zero, the block flags an interrupt and starts counting again from the reload value. If software does not service the interrupt and the counter reaches zero a second time, the block raises a system reset request, provided the reset-enable bit is set. Software services the watchdog by writing to the interrupt-clear register, which also restarts the count.

A write-lock guards the configuration against stray writes. Any write to the lock register locks every other register. Only the key value `0x1ACC_E551` unlocks them. Reads have no wait states: `bus_rdata` is a combinational function of `bus_addr`. Writes take effect at the clock edge on which `bus_we` is high.

The sequencer has four states. IDLE: disabled, counter frozen. ARMED: counting, no interrupt pending. PENDING: counting with the interrupt pending. TRIPPED: reset requested, counter frozen. The transitions are:
- ENABLE: IDLE to ARMED on an accepted control write with bit 0 set.
- FIRST_EXPIRY: ARMED to PENDING when the counter is zero.
- SERVICE: PENDING to ARMED on an accepted interrupt-clear write.
- REARM: PENDING to PENDING on zero with reset disabled.
- TRIP: PENDING to TRIPPED on zero with reset enabled.

Top module: `wdog_core`

## Requirements
- R1: After reset the reload register (offset 0x000) and the counter value (offset 0x004) read 0xFFFF_FFFF. Control (0x008), raw status (0x010), masked status (0x014) and lock state (0xC00) all read 0. `irq_o` and `sys_rst_req_o` are low.
- R2: An accepted control write with bit 0 set starts the count, and the counter is preloaded from the reload register at that edge. While the block is disabled, a reload-register write changes only the reload register, not the counter.
- R3: While counting, the counter drops by one on each clock. On a clock where it is zero and the block is in ARMED, raw status bit 0 becomes 1 and the counter is reloaded. The period is therefore reload+1 cycles.
- R4: On a clock where the counter is zero in PENDING:
  - With control bit 1 set, `sys_rst_req_o` rises after that edge. It then stays high, and the counter stays frozen, until `rst_n` is asserted.
  - With control bit 1 clear, the counter reloads and the interrupt stays pending.
- R5: An accepted write of any data to offset 0x00C clears raw status and reloads the counter from the reload register. Offset 0x00C reads as 0.
- R6: An accepted reload-register write while counting puts the written value into the counter at that edge. It leaves a pending interrupt pending.
- R7: Control bit 0 (enable) can be set but not cleared by a write. Control bit 1 (reset enable) follows each accepted control write.
- R8: `irq_o` and masked status bit 0 equal raw status bit 0 ANDed with control bit 0.
- R9: Lock behaviour at offset 0xC00:
  - A write of 0x1ACC_E551 to 0xC00 unlocks. Any other value written there locks.
  - Writes to 0xC00 are always accepted. Reading 0xC00 returns 1 while locked and 0 while unlocked.
  - While locked, writes to 0x000, 0x008 and 0x00C have no effect.
- R10: The value register at 0x004 is read-only: a write there leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Masked interrupt request |
| sys_rst_req_o | output | 1 | System reset request, held until `rst_n` |

## Verification
The bench sweeps small reload values, including zero, against a cycle model of the counter. It runs each value with and without reset enable, and checks the exact edge of the first expiry, the rearm and the trip. An off-by-one reload, or a trip on the first expiry, shows up as a value or reset-line mismatch on a specific cycle. Other targeted checks cover:
- a reload write that touches the counter while the block is idle;
- a reload write in PENDING that drops the interrupt;
- an enable bit that can be cleared by a write;
- locked writes that still land, and a near-miss key that unlocks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_PENDING,
        ST_TRIPPED
    } wd_state_e;

    localparam logic [ADDR_W-1:0] OFS_RELOAD = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_VALUE  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_ICLR   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'hC00;

    localparam logic [31:0] DEFAULT_KEY = 32'h1ACC_E551;

endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_new,
    input  logic [CNT_W-1:0] new_val,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt_q,
    output logic             at_zero
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (take_new) begin
            cnt_q <= new_val;
        end else if (reload) begin
            cnt_q <= reload_val;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign at_zero = (cnt_q == '0);

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic at_zero,
    input  logic load_wr,
    input  logic iclr_wr,
    input  logic rst_en,
    output logic raw_irq,
    output logic trip,
    output logic cnt_take,
    output logic cnt_reload,
    output logic cnt_dec
);

    wd_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_ARMED;                 // ENABLE
            end
            ST_ARMED: begin
                if (!iclr_wr && !load_wr && at_zero)
                    state_d = ST_PENDING;                      // FIRST_EXPIRY
            end
            ST_PENDING: begin
                if (iclr_wr) begin
                    state_d = ST_ARMED;                        // SERVICE
                end else if (!load_wr && at_zero && rst_en) begin
                    state_d = ST_TRIPPED;                      // TRIP
                end
            end
            ST_TRIPPED: begin
                state_d = ST_TRIPPED;
            end
        endcase
    end

    // outputs
    always_comb begin
        cnt_take   = 1'b0;
        cnt_reload = 1'b0;
        cnt_dec    = 1'b0;
        raw_irq    = 1'b0;
        trip       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_reload = start;
            end
            ST_ARMED: begin
                if (iclr_wr)      cnt_reload = 1'b1;
                else if (load_wr) cnt_take   = 1'b1;
                else if (at_zero) cnt_reload = 1'b1;
                else              cnt_dec    = 1'b1;
            end
            ST_PENDING: begin
                raw_irq = 1'b1;
                if (iclr_wr)      cnt_reload = 1'b1;
                else if (load_wr) cnt_take   = 1'b1;
                else if (at_zero) cnt_reload = !rst_en;        // REARM
                else              cnt_dec    = 1'b1;
            end
            ST_TRIPPED: begin
                raw_irq = 1'b1;
                trip    = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          CNT_W      = 32,
    parameter logic [31:0] UNLOCK_KEY = DEFAULT_KEY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              raw_irq,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  load_q,
    output logic              int_en,
    output logic              rst_en,
    output logic              locked,
    output logic              start,
    output logic              load_wr,
    output logic              iclr_wr
);

    logic accept;

    assign accept  = bus_we && !locked;
    assign load_wr = accept && (bus_addr == OFS_RELOAD);
    assign iclr_wr = accept && (bus_addr == OFS_ICLR);
    assign start   = accept && (bus_addr == OFS_CTRL) && bus_wdata[0] && !int_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '1;
            int_en <= 1'b0;
            rst_en <= 1'b0;
            locked <= 1'b0;
        end else begin
            if (bus_we && bus_addr == OFS_LOCK) begin
                locked <= (bus_wdata[31:0] != UNLOCK_KEY);
            end
            if (load_wr) begin
                load_q <= bus_wdata[CNT_W-1:0];
            end
            if (accept && bus_addr == OFS_CTRL) begin
                int_en <= int_en | bus_wdata[0];
                rst_en <= bus_wdata[1];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_RELOAD: bus_rdata[CNT_W-1:0] = load_q;
            OFS_VALUE:  bus_rdata[CNT_W-1:0] = cnt_val;
            OFS_CTRL:   bus_rdata[1:0]       = {rst_en, int_en};
            OFS_RAW:    bus_rdata[0]         = raw_irq;
            OFS_MASKED: bus_rdata[0]         = raw_irq & int_en;
            OFS_LOCK:   bus_rdata[0]         = locked;
            default:    bus_rdata            = '0;
        endcase
    end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          CNT_W      = 32,
    parameter logic [31:0] UNLOCK_KEY = DEFAULT_KEY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_req_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_q;
    logic int_en, rst_en, locked;
    logic start, load_wr, iclr_wr;
    logic at_zero, raw_irq, trip;
    logic cnt_take, cnt_reload, cnt_dec;

    wdog_regs #(
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .UNLOCK_KEY(UNLOCK_KEY)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .cnt_val  (cnt_q),
        .raw_irq  (raw_irq),
        .bus_rdata(bus_rdata),
        .load_q   (load_q),
        .int_en   (int_en),
        .rst_en   (rst_en),
        .locked   (locked),
        .start    (start),
        .load_wr  (load_wr),
        .iclr_wr  (iclr_wr)
    );

    wdog_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .at_zero   (at_zero),
        .load_wr   (load_wr),
        .iclr_wr   (iclr_wr),
        .rst_en    (rst_en),
        .raw_irq   (raw_irq),
        .trip      (trip),
        .cnt_take  (cnt_take),
        .cnt_reload(cnt_reload),
        .cnt_dec   (cnt_dec)
    );

    wdog_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_new  (cnt_take),
        .new_val   (bus_wdata[CNT_W-1:0]),
        .reload    (cnt_reload),
        .reload_val(load_q),
        .dec       (cnt_dec),
        .cnt_q     (cnt_q),
        .at_zero   (at_zero)
    );

    assign irq_o         = raw_irq & int_en;
    assign sys_rst_req_o = trip;

endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_o,
    input logic              sys_rst_req_o,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  load_val,
    input logic              ie,
    input logic              ris,
    input logic              locked
);

    // R4: reset request is held
    a_r4_trip_held: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req_o |=> sys_rst_req_o && $stable(cnt));

    // R7: enable cannot be cleared
    a_r7_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ie |=> ie);

    // R8: interrupt needs enable
    a_r8_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ie && ris);

    // R3: steady decrement
    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (ie && !sys_rst_req_o && !bus_we && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

    // R3: reload on zero unless trip
    a_r3_zero_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (ie && !sys_rst_req_o && !bus_we && cnt == '0) |=> (cnt == load_val) || sys_rst_req_o);

    // R5: clear removes pending interrupt
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_ICLR && !locked && !sys_rst_req_o) |=> !ris);

    // R6: running reload write lands in counter
    a_r6_live_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_RELOAD && !locked && ie && !sys_rst_req_o)
        |=> cnt == $past(bus_wdata[CNT_W-1:0]));

    // R9: locked reload write ignored
    a_r9_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && locked && bus_addr == OFS_RELOAD) |=> $stable(load_val));

endmodule

bind wdog_core wdog_core_chk #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .irq_o        (irq_o),
    .sys_rst_req_o(sys_rst_req_o),
    .cnt          (cnt_q),
    .load_val     (load_q),
    .ie           (int_en),
    .ris          (raw_irq),
    .locked       (locked)
);

// File: tb/sim_wdog_core.sv
`timescale 1ns/1ps
module sim_wdog_core;

    localparam logic [11:0] A_LOAD = 12'h000;
    localparam logic [11:0] A_VAL  = 12'h004;
    localparam logic [11:0] A_CTRL = 12'h008;
    localparam logic [11:0] A_ICLR = 12'h00C;
    localparam logic [11:0] A_RAW  = 12'h010;
    localparam logic [11:0] A_MSK  = 12'h014;
    localparam logic [11:0] A_LOCK = 12'hC00;
    localparam logic [31:0] KEY    = 32'h1ACC_E551;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, sys_rst_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdog_core u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq_o        (irq_o),
        .sys_rst_req_o(sys_rst_req_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_we = 1'b0;
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        do_reset();

        // R1 reset values
        rd(A_LOAD, r); check("R1 reload", r, 32'hFFFF_FFFF);
        rd(A_VAL, r);  check("R1 value", r, 32'hFFFF_FFFF);
        rd(A_CTRL, r); check("R1 ctrl", r, 0);
        rd(A_RAW, r);  check("R1 raw", r, 0);
        rd(A_MSK, r);  check("R1 masked", r, 0);
        rd(A_LOCK, r); check("R1 lock", r, 0);
        check("R1 irq", {31'b0, irq_o}, 0);
        check("R1 rst", {31'b0, sys_rst_req_o}, 0);

        // R2, R10 idle writes do not touch counter
        wr(A_LOAD, 5);
        rd(A_VAL, r);  check("R2 idle value", r, 32'hFFFF_FFFF);
        rd(A_LOAD, r); check("R2 idle reload", r, 5);
        wr(A_VAL, 9);
        rd(A_VAL, r);  check("R10 value read-only", r, 32'hFFFF_FFFF);

        // R2 R3 R4 R8 sweep against cycle model
        for (int ren = 0; ren < 2; ren++) begin
            for (int L = 0; L < 5; L++) begin
                int  cnt;
                bit  pend, trp;
                do_reset();
                wr(A_LOAD, L);
                wr(A_CTRL, ren ? 32'd3 : 32'd1);
                cnt = L; pend = 0; trp = 0;
                rd(A_VAL, r); check("R2 preload", r, L);
                for (int k = 0; k < 3 * L + 6; k++) begin
                    @(negedge clk);
                    if (!trp) begin
                        if (cnt == 0) begin
                            if (pend && ren == 1) trp = 1;
                            else begin cnt = L; pend = 1; end
                        end else cnt--;
                    end
                    rd(A_VAL, r); check("R3 value", r, cnt);
                    check("R8 irq", {31'b0, irq_o}, {31'b0, pend});
                    check("R4 reset req", {31'b0, sys_rst_req_o}, {31'b0, trp});
                end
                rd(A_MSK, r); check("R8 masked", r, {31'b0, pend});
            end
        end

        // R7 control bits
        do_reset();
        wr(A_LOAD, 50);
        wr(A_CTRL, 1);
        wr(A_CTRL, 2);
        rd(A_CTRL, r); check("R7 enable sticky, reset-en set", r, 3);
        wr(A_CTRL, 0);
        rd(A_CTRL, r); check("R7 clear only reset-en", r, 1);

        // R6 R5 live reload and clear
        do_reset();
        wr(A_LOAD, 6);
        wr(A_CTRL, 1);
        repeat (7) @(negedge clk);
        rd(A_RAW, r);  check("R3 first expiry", r, 1);
        rd(A_VAL, r);  check("R3 reloaded", r, 6);
        wr(A_LOAD, 20);
        rd(A_VAL, r);  check("R6 live reload", r, 20);
        rd(A_RAW, r);  check("R6 pending kept", r, 1);
        wr(A_ICLR, 0);
        rd(A_RAW, r);  check("R5 clear raw", r, 0);
        rd(A_VAL, r);  check("R5 clear reloads", r, 20);
        rd(A_ICLR, r); check("R5 clear reads zero", r, 0);
        check("R8 irq low", {31'b0, irq_o}, 0);

        // R9 lock
        wr(A_LOCK, 0);
        rd(A_LOCK, r); check("R9 locked", r, 1);
        wr(A_LOAD, 3);
        rd(A_LOAD, r); check("R9 locked reload", r, 20);
        wr(A_CTRL, 2);
        rd(A_CTRL, r); check("R9 locked ctrl", r, 1);
        wr(A_LOCK, KEY ^ 32'h1);
        rd(A_LOCK, r); check("R9 wrong key", r, 1);
        wr(A_LOCK, KEY);
        rd(A_LOCK, r); check("R9 unlocked", r, 0);
        wr(A_LOAD, 3);
        rd(A_LOAD, r); check("R9 write after unlock", r, 3);

        // R9 locked clear ignored
        do_reset();
        wr(A_LOAD, 2);
        wr(A_CTRL, 1);
        repeat (3) @(negedge clk);
        wr(A_LOCK, 32'h55);
        wr(A_ICLR, 0);
        rd(A_RAW, r);  check("R9 locked clear ignored", r, 1);
        wr(A_LOCK, KEY);
        wr(A_ICLR, 0);
        rd(A_RAW, r);  check("R9 clear after unlock", r, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule